// File: doc/BRIEF.md
# Data-Memory Request Steering Unit

This unit sits between the data-memory port of a small 8-bit processor and two targets: an on-chip expanded RAM and a multiplexed external bus. For each request it decides which target serves the access. The decision uses three inputs: a route-select bit, the addressing mode of the request (an 8-bit register-indirect form or a 16-bit pointer form), and the size of the on-chip RAM.

Internal accesses drive a simple synchronous RAM port and leave every external pin alone. External accesses run a fixed sequence. First an address-latch pulse puts the low address byte on the shared low port. Then an active-low read or write strobe follows, lasting 6 clocks, or 30 clocks when the stretch bit is set.

The requester raises `req` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse, which also carries read data. The high-address port only changes on external 16-bit accesses. External 8-bit accesses therefore reuse whatever page byte was last placed there.

Top module: `xms_steer`

## Requirements
- R1: With `ext_sel`=0, a request whose effective address is below IRAM_SIZE (768 by default) is served internally. `iram_en` is high for exactly one cycle with `iram_addr` equal to the effective address, `iram_we`=`wr` and `iram_wdata`=`wdata`. `done` follows in the next cycle, and on a read `rdata` equals the RAM output.
- R2: During an internal access `ale` stays 0, `rd_n` and `wr_n` stay 1, `lo_oe` stays 0 and `hi_addr` keeps its value.
- R3: When `ptr16`=0 the effective address is `{8'h00, addr[7:0]}`; `addr[15:8]` has no effect on routing or on the RAM address.
- R4: With `ext_sel`=0 and `ptr16`=1, an address at or above IRAM_SIZE goes to the external bus and `iram_en` stays 0.
- R5: With `ext_sel`=1, requests of both modes go to the external bus, whatever the address.
- R6: An external access starts with exactly one cycle of `ale`=1, with `lo_oe`=1 and `lo_out`=`addr[7:0]`. No strobe is active before or during that cycle.
- R7: An external access with `ptr16`=1 sets `hi_addr` to `addr[15:8]`. An external access with `ptr16`=0 leaves `hi_addr` unchanged.
- R8: An external write holds `wr_n`=0 with `lo_oe`=1 and `lo_out`=`wdata` for the whole strobe. An external read holds `rd_n`=0 with `lo_oe`=0. The two strobes are never low together.
- R9: The strobe lasts 6 cycles when `stretch` is 0 at the request, and 30 cycles when it is 1.
- R10: External read data is taken from `lo_in` in the last strobe cycle only. It is presented on `rdata` with a one-cycle `done` pulse in the cycle after the strobe ends.
- R11: A request while `busy` is 1, including the cycle in which `done` is high, is ignored.
- R12: A synchronous active-low reset returns the unit to idle. After reset, `busy`, `done`, `ale`, `lo_oe` and `iram_en` are 0, `rd_n` and `wr_n` are 1, and `hi_addr` is 00h. This holds even when reset arrives in the middle of a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, taken when `busy` is 0 |
| wr | input | 1 | 1 = write, 0 = read |
| ptr16 | input | 1 | 1 = 16-bit pointer mode, 0 = 8-bit register-indirect mode |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ext_sel | input | 1 | 1 = send every access to the external bus |
| stretch | input | 1 | 1 = 30-cycle strobe, 0 = 6-cycle strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `done` |
| iram_en | output | 1 | On-chip RAM enable |
| iram_we | output | 1 | On-chip RAM write enable |
| iram_addr | output | IA_W (10) | On-chip RAM address |
| iram_wdata | output | 8 | On-chip RAM write data |
| iram_rdata | input | 8 | On-chip RAM read data, one cycle after enable |
| lo_out | output | 8 | Low address / write data out |
| lo_oe | output | 1 | Output enable for `lo_out` |
| lo_in | input | 8 | Low port read data in |
| hi_addr | output | 8 | High address byte (page) |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. This happens when the requester keeps `req` high through an access and past its `done` cycle. The bench provokes it by holding `req` asserted until the edge that closes the `done` cycle. It then judges that exactly one address-latch pulse and one strobe of the expected length were produced, and that the unit is idle, with no further latch, strobe or RAM enable, in the cycles that follow. A second overlap, reset landing inside a stretched read strobe, is checked by confirming that the strobe is released at once.

// File: rtl/xms_pkg.sv
// Shared types for the data-memory steering unit.
// Assumes: one access in flight at a time.
package xms_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_IACC  = 3'd1,
        S_IDONE = 3'd2,
        S_ALE   = 3'd3,
        S_STRB  = 3'd4,
        S_XDONE = 3'd5
    } xms_state_e;
endpackage

// File: rtl/xms_route.sv
// Route decoder: forms the effective address from the addressing mode and
// decides internal versus external service.
// Assumes: IRAM_SIZE <= 65536; IA_W wide enough for IRAM_SIZE-1.
module xms_route #(
    parameter int IRAM_SIZE = 768,
    parameter int IA_W      = 10
) (
    input  logic            ptr16,
    input  logic            ext_sel,
    input  logic [15:0]     addr,
    output logic            to_int,
    output logic [IA_W-1:0] iaddr
);
    localparam logic [16:0] LIMIT = 17'(IRAM_SIZE);

    logic [15:0] eff;

    // effective address: 8-bit mode ignores the upper byte
    always_comb begin
        eff    = ptr16 ? addr : {8'h00, addr[7:0]};
        to_int = !ext_sel && ({1'b0, eff} < LIMIT);
        iaddr  = eff[IA_W-1:0];
    end
endmodule

// File: rtl/xms_timer.sv
// Strobe width counter: loaded with the selected width, counts down while
// the strobe runs, flags the final strobe cycle.
// Assumes: load and run are never high together.
module xms_timer #(
    parameter int SHORT = 6,
    parameter int LONG  = 30,
    localparam int CW   = $clog2(LONG)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stretch,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt;

    // load width minus one, then count down during the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= stretch ? CW'(LONG - 1) : CW'(SHORT - 1);
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign last = run && (cnt == '0);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LONG - 1));
endmodule

// File: rtl/xms_page_reg.sv
// High-address page register: keeps the upper address byte between
// external 16-bit accesses.
// Assumes: load is a single-cycle pulse.
module xms_page_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] d,
    output logic [7:0] q
);
    // capture the page byte when loaded
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 8'h00;
        else if (load) q <= d;
    end

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/xms_steer.sv
// Data-memory steering unit top: accepts one request at a time, serves it
// from on-chip RAM or runs an external latch + strobe bus cycle.
// Assumes: the on-chip RAM returns read data one cycle after enable.
module xms_steer
    import xms_pkg::*;
#(
    parameter int IRAM_SIZE = 768,
    parameter int SHORT_W   = 6,
    parameter int LONG_W    = 30,
    localparam int IA_W     = $clog2(IRAM_SIZE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            wr,
    input  logic            ptr16,
    input  logic [15:0]     addr,
    input  logic [7:0]      wdata,
    input  logic            ext_sel,
    input  logic            stretch,
    output logic            busy,
    output logic            done,
    output logic [7:0]      rdata,
    output logic            iram_en,
    output logic            iram_we,
    output logic [IA_W-1:0] iram_addr,
    output logic [7:0]      iram_wdata,
    input  logic [7:0]      iram_rdata,
    output logic [7:0]      lo_out,
    output logic            lo_oe,
    input  logic [7:0]      lo_in,
    output logic [7:0]      hi_addr,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n
);
    xms_state_e      state, nstate;
    logic            to_int, accept, last;
    logic [IA_W-1:0] iaddr, iaddr_q;
    logic            wr_q, str_q;
    logic [7:0]      lo_q, wdata_q, rdata_q;

    xms_route #(.IRAM_SIZE(IRAM_SIZE), .IA_W(IA_W)) u_route (
        .ptr16(ptr16), .ext_sel(ext_sel), .addr(addr),
        .to_int(to_int), .iaddr(iaddr)
    );

    xms_timer #(.SHORT(SHORT_W), .LONG(LONG_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(state == S_ALE), .stretch(str_q),
        .run(state == S_STRB), .last(last)
    );

    xms_page_reg u_page (
        .clk(clk), .rst_n(rst_n), .load(accept && !to_int && ptr16),
        .d(addr[15:8]), .q(hi_addr)
    );

    assign accept = req && (state == S_IDLE);

    // next-state sequencing of internal and external cycles
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (accept) nstate = to_int ? S_IACC : S_ALE;
            S_IACC:  nstate = S_IDONE;
            S_IDONE: nstate = S_IDLE;
            S_ALE:   nstate = S_STRB;
            S_STRB:  if (last) nstate = S_XDONE;
            S_XDONE: nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // capture request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            str_q   <= 1'b0;
            lo_q    <= 8'h00;
            wdata_q <= 8'h00;
            iaddr_q <= '0;
        end else if (accept) begin
            wr_q    <= wr;
            str_q   <= stretch;
            lo_q    <= addr[7:0];
            wdata_q <= wdata;
            iaddr_q <= iaddr;
        end
    end

    // sample external read data in the last strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata_q <= 8'h00;
        else if (state == S_STRB && last && !wr_q) rdata_q <= lo_in;
    end

    // output decode from state
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_IDONE) || (state == S_XDONE);
        rdata      = (state == S_IDONE) ? iram_rdata : rdata_q;
        iram_en    = (state == S_IACC);
        iram_we    = (state == S_IACC) && wr_q;
        iram_addr  = iaddr_q;
        iram_wdata = wdata_q;
        ale        = (state == S_ALE);
        rd_n       = !((state == S_STRB) && !wr_q);
        wr_n       = !((state == S_STRB) && wr_q);
        lo_oe      = (state == S_ALE) || ((state == S_STRB) && wr_q);
        lo_out     = (state == S_ALE) ? lo_q :
                     (((state == S_STRB) && wr_q) ? wdata_q : 8'h00);
    end

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6
    ale_leads_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));

    // R2
    internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iram_en |-> (rd_n && wr_n && !ale && !lo_oe));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ale && !iram_en);
endmodule

// File: tb/tb_xms_steer.sv
`timescale 1ns/100ps
module tb_xms_steer;
    localparam int IRAM = 768;
    localparam int AW   = 10;
    localparam int NV   = 11;

    // {wr, ptr16, ext_sel, stretch, exp_internal, addr[15:0], wdata[7:0]}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0123, 8'h00},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h02FF, 8'hB7},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0300, 8'h4D},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8A55, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hC0A0, 8'hE1},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h77A0, 8'h00},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234, 8'h00},
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0010, 8'h96},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h4321, 8'h00},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFF5A, 8'h3B},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h02FF, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0, ptr16 = 1'b0, ext_sel = 1'b0, stretch = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0, lo_in = 8'h0;
    logic busy, done, iram_en, iram_we, lo_oe, ale, rd_n, wr_n;
    logic [7:0] rdata, iram_wdata, lo_out, hi_addr;
    logic [7:0] iram_rdata;
    logic [AW-1:0] iram_addr;

    int checks = 0, bad = 0;
    logic [7:0] ram [IRAM];
    logic [7:0] shadow [IRAM];
    logic [7:0] ram_q;

    always #2.5 clk = ~clk;

    xms_steer dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ptr16(ptr16),
        .addr(addr), .wdata(wdata), .ext_sel(ext_sel), .stretch(stretch),
        .busy(busy), .done(done), .rdata(rdata), .iram_en(iram_en),
        .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
        .iram_rdata(iram_rdata), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
        .hi_addr(hi_addr), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // behavioural on-chip RAM, preloaded during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IRAM; i++) ram[i] <= 8'(i) ^ 8'h5C;
            ram_q <= 8'h00;
        end else if (iram_en) begin
            if (iram_we) ram[iram_addr] <= iram_wdata;
            else         ram_q <= ram[iram_addr];
        end
    end
    assign iram_rdata = ram_q;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; called at a negedge, returns at a negedge
    task automatic access(input logic w, input logic p, input logic x, input logic s,
                          input logic [15:0] a, input logic [7:0] d,
                          input logic eint, input string rtag, input bit hold);
        int ale_n = 0, strb_n = 0, ien_n = 0, cyc = 0;
        bit bad_order = 0, bad_ale = 0, bad_data = 0, bad_quiet = 0, bad_int = 0;
        bit seen_done = 0;
        int width = s ? 30 : 6;
        logic [7:0] hi_before = hi_addr;
        logic [7:0] xdat = a[7:0] ^ 8'h3C;
        logic [7:0] got = 8'h00, exp_hi;
        logic [15:0] eff = p ? a : {8'h00, a[7:0]};
        req = 1'b1; wr = w; ptr16 = p; ext_sel = x; stretch = s; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        if (!hold) begin
            req = 1'b0; addr = ~a; wr = ~w; ptr16 = ~p; stretch = ~s;
        end
        while (!seen_done && cyc < 80) begin
            if (ale) begin
                ale_n++;
                if (lo_out != a[7:0] || !lo_oe || !rd_n || !wr_n) bad_ale = 1;
            end
            if (!rd_n || !wr_n) begin
                if (ale_n == 0) bad_order = 1;
                strb_n++;
                if (!wr_n && (!w || !lo_oe || lo_out != d)) bad_data = 1;
                if (!rd_n) begin
                    if (w || lo_oe) bad_data = 1;
                    lo_in = (strb_n == width) ? xdat : ~xdat;
                end
            end
            if (iram_en) begin
                ien_n++;
                if (iram_addr != eff[AW-1:0] || iram_we != w || (w && iram_wdata != d))
                    bad_int = 1;
            end
            if (eint && (ale || !rd_n || !wr_n || lo_oe || hi_addr != hi_before))
                bad_quiet = 1;
            if (done) begin seen_done = 1; got = rdata; end
            @(negedge clk);
            cyc++;
        end
        if (hold) req = 1'b0;
        chk(seen_done, "done seen R10", int'(seen_done), 1);
        if (eint) begin
            chk(ien_n == 1 && !bad_int, {rtag, " internal port R1"}, ien_n, 1);
            chk(!bad_quiet, "external pins quiet R2", int'(bad_quiet), 0);
            if (!w) chk(got == shadow[eff[AW-1:0]], {rtag, " internal read R1"},
                        int'(got), int'(shadow[eff[AW-1:0]]));
            else shadow[eff[AW-1:0]] = d;
        end else begin
            exp_hi = p ? a[15:8] : hi_before;
            chk(ien_n == 0, {rtag, " routed external"}, ien_n, 0);
            chk(ale_n == 1 && !bad_order && !bad_ale, "latch cycle R6", ale_n, 1);
            chk(strb_n == width, "strobe width R9", strb_n, width);
            chk(!bad_data, "strobe data R8", int'(bad_data), 0);
            chk(hi_addr == exp_hi, "page byte R7", int'(hi_addr), int'(exp_hi));
            if (!w) chk(got == xdat, "read sample R10", int'(got), int'(xdat));
        end
        if (hold) begin
            bit stray = 0;
            for (int k = 0; k < 20; k++) begin
                if (busy || ale || !rd_n || !wr_n || iram_en) stray = 1;
                @(negedge clk);
            end
            chk(!stray, "request during done ignored R11", int'(stray), 0);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < IRAM; i++) shadow[i] = 8'(i) ^ 8'h5C;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !ale && !lo_oe && !iram_en, "reset idle R12",
            {busy, done, ale, lo_oe, iram_en}, 0);
        chk(rd_n && wr_n && hi_addr == 8'h00, "reset strobes/page R12",
            {rd_n, wr_n, hi_addr}, 10'h300);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v = VEC[i];
            string t = v[24] ? (v[27] ? "R1" : "R3") : (v[26] ? "R5" : "R4");
            access(v[28], v[27], v[26], v[25], v[23:8], v[7:0], v[24], t, 1'b0);
        end

        // R11: request held through done, external 16-bit read
        access(1'b0, 1'b1, 1'b0, 1'b0, 16'hA3C4, 8'h00, 1'b0, "R4", 1'b1);
        // R11: held request on an internal write
        access(1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 8'h6E, 1'b1, "R1", 1'b1);
        // R3: 8-bit mode at top of page with high byte beyond RAM size
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 8'h00, 1'b1, "R3", 1'b0);

        // R12: reset in the middle of a stretched read strobe
        req = 1'b1; wr = 1'b0; ptr16 = 1'b1; ext_sel = 1'b1; stretch = 1'b1; addr = 16'h5511;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        chk(!rd_n, "strobe active before reset R9", int'(rd_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rd_n && wr_n && !busy && hi_addr == 8'h00, "reset mid-strobe R12",
            {rd_n, wr_n, busy, hi_addr}, 11'h600);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < IRAM; i++) shadow[i] = 8'(i) ^ 8'h5C;
        // after reset, 8-bit external access keeps page 00h
        access(1'b1, 1'b0, 1'b1, 1'b0, 16'h9977, 8'h21, 1'b0, "R5", 1'b0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule